// File: doc/BRIEF.md
# Unlock-sequence flash command decoder

This block sits between a host write bus and the control side of a flash array. It decodes host write cycles into flash operations. A command is recognised only after a fixed pair of unlock writes. Operations that change or protect the array also need a setup code and a second unlock pair before the final write. Each accepted command produces one single-cycle pulse on its own output, which the program/erase engine and status logic consume.

The block keeps a read-path select that tells the read multiplexer where host reads come from: the array, the identifier codes or the status register. When the select points at the identifier, the block also supplies the identifier word. A sector field is captured from the final write of sector erase and of protect/unprotect. A busy input from the program/erase engine blocks the read/reset command while an operation runs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `read_sel` is 0 (array), every command pulse is low and `id_data` is 0.
- R2: A command is recognised only after data AAh at unlock address 5555h, then 55h at 2AAAh, then the command code at 5555h. Only address bits 14..0 take part in these compares, so bits 19..15 may hold any value. Third-cycle codes are F0h reset, 90h identifier, A0h program, 70h status, 50h clear status, E0h abort, 80h erase setup and 60h protect setup.
- R3: Code F0h sets `read_sel` to 0 and pulses `cmd_read_reset`. While `busy` is high, the same sequence produces no pulse and leaves `read_sel` unchanged.
- R4: Code 90h sets `read_sel` to 1 (identifier). In that mode, `id_data` is 00C2h when `rd_offset` is 0 and 00F6h when it is 1. In any other mode, `id_data` is 0.
- R5: Code A0h pulses `cmd_page_program` and sets `read_sel` to 2 (status). Code 70h sets `read_sel` to 2 and produces no pulse.
- R6: Code 50h pulses `cmd_clear_status` and code E0h pulses `cmd_abort`. Neither changes `read_sel`.
- R7: After setup code 80h, a second unlock pair followed by 10h at 5555h pulses `cmd_chip_erase`. If that final write is instead 30h at any address, it pulses `cmd_sector_erase` and loads `sector` with address bits 19..15. Both set `read_sel` to 2.
- R8: After setup code 60h and a second unlock pair, 20h pulses `cmd_protect` and 40h pulses `cmd_unprotect`, and `sector` is loaded from address bits 19..15. This happens only when those bits are 00000b or 11111b. For any other sector there is no pulse and `sector` keeps its value.
- R9: A write that breaks the expected sequence, either a wrong address or an unknown code, returns the decoder to idle with no pulse and `read_sel` unchanged. A complete sequence written afterwards is accepted.
- R10: Each command pulse lasts one cycle and appears in the cycle after the accepting write. At most one pulse is high at a time, and no pulse follows a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Low data byte of the write |
| busy | input | 1 | Program or erase in progress |
| rd_offset | input | 1 | Identifier word select for reads |
| read_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_data | output | 16 | Identifier word, zero-extended |
| sector | output | 5 | Last accepted sector address |
| cmd_read_reset | output | 1 | Read/reset pulse |
| cmd_page_program | output | 1 | Page program start pulse |
| cmd_chip_erase | output | 1 | Chip erase start pulse |
| cmd_sector_erase | output | 1 | Sector erase start pulse |
| cmd_protect | output | 1 | Sector protect pulse |
| cmd_unprotect | output | 1 | Sector unprotect pulse |
| cmd_clear_status | output | 1 | Clear status pulse |
| cmd_abort | output | 1 | Abort pulse |

## Verification
The assertions assume that `wr_en` lasts exactly one clock per host bus write. They also assume that `busy` is a level from the engine that only changes between command sequences. The stimulus raises each write for a single cycle and leaves at least one idle cycle between writes. It changes `busy` only while no sequence is in flight, so a pulse is never judged against a busy value from mid-sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_SETUP,
        ST_SUNL1,
        ST_SUNL2
    } seq_st_t;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2
    } rd_sel_t;

    typedef struct packed {
        logic rst;
        logic prog;
        logic chip;
        logic sect;
        logic prot;
        logic unprot;
        logic clr;
        logic abort;
    } cmd_pulse_t;

    localparam logic [7:0] K_UNL_A   = 8'hAA;
    localparam logic [7:0] K_UNL_B   = 8'h55;
    localparam logic [7:0] K_RESET   = 8'hF0;
    localparam logic [7:0] K_IDENT   = 8'h90;
    localparam logic [7:0] K_PROG    = 8'hA0;
    localparam logic [7:0] K_STATUS  = 8'h70;
    localparam logic [7:0] K_CLR     = 8'h50;
    localparam logic [7:0] K_ABORT   = 8'hE0;
    localparam logic [7:0] K_ESETUP  = 8'h80;
    localparam logic [7:0] K_PSETUP  = 8'h60;
    localparam logic [7:0] K_CHIP    = 8'h10;
    localparam logic [7:0] K_SECT    = 8'h30;
    localparam logic [7:0] K_PROT    = 8'h20;
    localparam logic [7:0] K_UNPROT  = 8'h40;

endpackage

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
    parameter int SECT_W = 5
) (
    input  logic [SECT_W-1:0] sect_in,
    output logic              edge_sector
);
    localparam logic [SECT_W-1:0] LOW_S  = '0;
    localparam logic [SECT_W-1:0] HIGH_S = '1;

    always_comb begin
        edge_sector = (sect_in == LOW_S) || (sect_in == HIGH_S);
    end
endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux
    import flash_cmd_pkg::*;
#(
    parameter int         DATA_W = 16,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'hF6
) (
    input  logic [1:0]        sel,
    input  logic              offset,
    output logic [DATA_W-1:0] id_word
);
    localparam int PAD_W = DATA_W - 8;

    always_comb begin
        id_word = '0;
        if (sel == RD_IDENT) begin
            id_word = {{PAD_W{1'b0}}, (offset ? DEV_CODE : MFR_CODE)};
        end
    end
endmodule

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CMP_W  = 15,
    parameter int SECT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              edge_sector,
    output logic [1:0]        sel,
    output logic [SECT_W-1:0] sect,
    output cmd_pulse_t        pulse
);
    localparam logic [CMP_W-1:0] ADR_A = CMP_W'(15'h5555);
    localparam logic [CMP_W-1:0] ADR_B = CMP_W'(15'h2AAA);

    typedef struct packed {
        seq_st_t           st;
        logic              prot_fam;
        rd_sel_t           rsel;
        logic [SECT_W-1:0] sct;
        cmd_pulse_t        pls;
    } dec_t;

    dec_t d_q, d_d;

    logic at_a, at_b;
    logic [SECT_W-1:0] wr_sect;

    always_comb begin
        at_a    = (wr_addr[CMP_W-1:0] == ADR_A);
        at_b    = (wr_addr[CMP_W-1:0] == ADR_B);
        wr_sect = wr_addr[ADDR_W-1 -: SECT_W];

        d_d     = d_q;
        d_d.pls = '0;
        if (wr_en) begin
            d_d.st = ST_IDLE;
            unique case (d_q.st)
                ST_IDLE:  if (at_a && wr_data == K_UNL_A) d_d.st = ST_UNL1;
                ST_UNL1:  if (at_b && wr_data == K_UNL_B) d_d.st = ST_UNL2;
                ST_UNL2: begin
                    if (at_a) begin
                        unique case (wr_data)
                            K_RESET: if (!busy) begin
                                d_d.rsel    = RD_ARRAY;
                                d_d.pls.rst = 1'b1;
                            end
                            K_IDENT:  d_d.rsel = RD_IDENT;
                            K_PROG: begin
                                d_d.rsel     = RD_STATUS;
                                d_d.pls.prog = 1'b1;
                            end
                            K_STATUS: d_d.rsel = RD_STATUS;
                            K_CLR:    d_d.pls.clr   = 1'b1;
                            K_ABORT:  d_d.pls.abort = 1'b1;
                            K_ESETUP: begin
                                d_d.st       = ST_SETUP;
                                d_d.prot_fam = 1'b0;
                            end
                            K_PSETUP: begin
                                d_d.st       = ST_SETUP;
                                d_d.prot_fam = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SETUP: if (at_a && wr_data == K_UNL_A) d_d.st = ST_SUNL1;
                ST_SUNL1: if (at_b && wr_data == K_UNL_B) d_d.st = ST_SUNL2;
                ST_SUNL2: begin
                    if (!d_q.prot_fam) begin
                        if (at_a && wr_data == K_CHIP) begin
                            d_d.pls.chip = 1'b1;
                            d_d.rsel     = RD_STATUS;
                        end else if (wr_data == K_SECT) begin
                            d_d.pls.sect = 1'b1;
                            d_d.rsel     = RD_STATUS;
                            d_d.sct      = wr_sect;
                        end
                    end else if (edge_sector) begin
                        if (wr_data == K_PROT) begin
                            d_d.pls.prot = 1'b1;
                            d_d.sct      = wr_sect;
                        end else if (wr_data == K_UNPROT) begin
                            d_d.pls.unprot = 1'b1;
                            d_d.sct        = wr_sect;
                        end
                    end
                end
                default: d_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q.st       <= ST_IDLE;
            d_q.prot_fam <= 1'b0;
            d_q.rsel     <= RD_ARRAY;
            d_q.sct      <= '0;
            d_q.pls      <= '0;
        end else begin
            d_q <= d_d;
        end
    end

    assign sel   = d_q.rsel;
    assign sect  = d_q.sct;
    assign pulse = d_q.pls;

    // R10: never two pulses at once
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));
    // R10: no pulse without a preceding write
    a_r10_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (pulse == '0));
    // R9: read select holds when nothing is written
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel));
    // R3: read/reset never issued while engine busy
    a_r3_no_reset_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && busy |=> !pulse.rst);
    // R8: protect operations only on the edge sectors
    a_r8_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse.prot || pulse.unprot) |-> (sect == '0 || sect == '1));
    // R5, R7: destructive starts route reads to status
    a_r7_status_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse.prog || pulse.chip || pulse.sect) |-> (sel == RD_STATUS));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CMP_W  = 15,
    parameter int SECT_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              rd_offset,
    output logic [1:0]        read_sel,
    output logic [DATA_W-1:0] id_data,
    output logic [SECT_W-1:0] sector,
    output logic              cmd_read_reset,
    output logic              cmd_page_program,
    output logic              cmd_chip_erase,
    output logic              cmd_sector_erase,
    output logic              cmd_protect,
    output logic              cmd_unprotect,
    output logic              cmd_clear_status,
    output logic              cmd_abort
);
    logic       edge_sector;
    cmd_pulse_t pulse;

    flash_sector_guard #(.SECT_W(SECT_W)) u_guard (
        .sect_in     (wr_addr[ADDR_W-1 -: SECT_W]),
        .edge_sector (edge_sector)
    );

    flash_unlock_fsm #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .SECT_W(SECT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .edge_sector (edge_sector),
        .sel         (read_sel),
        .sect        (sector),
        .pulse       (pulse)
    );

    flash_id_mux #(.DATA_W(DATA_W)) u_id (
        .sel     (read_sel),
        .offset  (rd_offset),
        .id_word (id_data)
    );

    assign cmd_read_reset   = pulse.rst;
    assign cmd_page_program = pulse.prog;
    assign cmd_chip_erase   = pulse.chip;
    assign cmd_sector_erase = pulse.sect;
    assign cmd_protect      = pulse.prot;
    assign cmd_unprotect    = pulse.unprot;
    assign cmd_clear_status = pulse.clr;
    assign cmd_abort        = pulse.abort;

    // R4: identifier word is silent outside identifier mode
    a_r4_id_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (read_sel != 2'd1) |-> (id_data == '0));
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        rd_offset = 1'b0;
    logic [1:0]  read_sel;
    logic [15:0] id_data;
    logic [4:0]  sector;
    logic cmd_read_reset, cmd_page_program, cmd_chip_erase, cmd_sector_erase;
    logic cmd_protect, cmd_unprotect, cmd_clear_status, cmd_abort;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_offset(rd_offset),
        .read_sel(read_sel), .id_data(id_data), .sector(sector),
        .cmd_read_reset(cmd_read_reset), .cmd_page_program(cmd_page_program),
        .cmd_chip_erase(cmd_chip_erase), .cmd_sector_erase(cmd_sector_erase),
        .cmd_protect(cmd_protect), .cmd_unprotect(cmd_unprotect),
        .cmd_clear_status(cmd_clear_status), .cmd_abort(cmd_abort)
    );

    // order: reset, program, chip, sector, protect, unprotect, clear, abort
    function automatic logic [7:0] pulses();
        return {cmd_read_reset, cmd_page_program, cmd_chip_erase, cmd_sector_erase,
                cmd_protect, cmd_unprotect, cmd_clear_status, cmd_abort};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmd3(input logic [7:0] code);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        wr(20'h05555, code);
    endtask

    task automatic cmd6(input logic [7:0] setup, input logic [19:0] a, input logic [7:0] d);
        cmd3(setup);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        wr(a, d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 read_sel", read_sel, 0);
        chk("R1 pulses", pulses(), 0);
        chk("R1 id_data", id_data, 0);
    endtask

    task automatic t_ident();
        wr(20'hA5555, 8'hAA);            // high address bits set: R2
        wr(20'hF2AAA, 8'h55);
        wr(20'h35555, 8'h90);
        chk("R2 high bits ignored, ident sel", read_sel, 1);
        rd_offset = 1'b0; #1;
        chk("R4 mfr code", id_data, 16'h00C2);
        rd_offset = 1'b1; #1;
        chk("R4 dev code", id_data, 16'h00F6);
        cmd3(8'hF0);
        chk("R3 reset pulse", pulses(), 8'h80);
        chk("R3 array sel", read_sel, 0);
        chk("R4 id silent in array mode", id_data, 0);
        @(negedge clk);
        chk("R10 pulse one cycle", pulses(), 0);
    endtask

    task automatic t_program_status();
        cmd3(8'hA0);
        chk("R5 program pulse", pulses(), 8'h40);
        chk("R5 program status sel", read_sel, 2);
        cmd3(8'hF0);
        cmd3(8'h70);
        chk("R5 status no pulse", pulses(), 0);
        chk("R5 status sel", read_sel, 2);
    endtask

    task automatic t_clear_abort();
        cmd3(8'h50);
        chk("R6 clear pulse", pulses(), 8'h02);
        chk("R6 clear keeps sel", read_sel, 2);
        cmd3(8'hE0);
        chk("R6 abort pulse", pulses(), 8'h01);
        chk("R6 abort keeps sel", read_sel, 2);
    endtask

    task automatic t_erase();
        cmd3(8'hF0);
        cmd6(8'h80, 20'h05555, 8'h10);
        chk("R7 chip pulse", pulses(), 8'h20);
        chk("R7 chip status sel", read_sel, 2);
        cmd3(8'hF0);
        cmd6(8'h80, {5'd13, 15'h0123}, 8'h30);
        chk("R7 sector pulse", pulses(), 8'h10);
        chk("R7 sector latched", sector, 13);
        chk("R7 sector status sel", read_sel, 2);
    endtask

    task automatic t_protect();
        cmd6(8'h60, {5'd31, 15'h0000}, 8'h20);
        chk("R8 protect top", pulses(), 8'h08);
        chk("R8 protect sector", sector, 31);
        cmd6(8'h60, {5'd0, 15'h0040}, 8'h40);
        chk("R8 unprotect bottom", pulses(), 8'h04);
        chk("R8 unprotect sector", sector, 0);
        cmd6(8'h60, {5'd5, 15'h0000}, 8'h20);
        chk("R8 mid sector refused", pulses(), 0);
        chk("R8 sector kept", sector, 0);
    endtask

    task automatic t_busy();
        cmd3(8'h70);
        busy = 1'b1;
        cmd3(8'hF0);
        chk("R3 busy no pulse", pulses(), 0);
        chk("R3 busy keeps sel", read_sel, 2);
        busy = 1'b0;
        cmd3(8'hF0);
        chk("R3 reset after busy", pulses(), 8'h80);
        chk("R3 sel array after busy", read_sel, 0);
    endtask

    task automatic t_broken();
        wr(20'h05555, 8'hAA);
        wr(20'h01234, 8'h55);            // wrong unlock address
        wr(20'h05555, 8'h90);
        chk("R9 bad unlock keeps sel", read_sel, 0);
        chk("R9 bad unlock no pulse", pulses(), 0);
        wr(20'h05555, 8'hAA);
        wr(20'h02AAA, 8'h55);
        wr(20'h01111, 8'hA0);            // code at wrong address
        chk("R2 wrong third address", pulses(), 0);
        chk("R2 wrong third address sel", read_sel, 0);
        cmd3(8'h33);                     // unknown code
        chk("R9 unknown code", pulses(), 0);
        chk("R9 unknown code sel", read_sel, 0);
        cmd3(8'h90);
        chk("R9 recovery", read_sel, 1);
        cmd6(8'h80, 20'h05555, 8'h77);   // bad final erase code
        chk("R9 bad erase final", pulses(), 0);
        chk("R9 bad erase final sel", read_sel, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ident();
        t_program_status();
        t_clear_abort();
        t_erase();
        t_protect();
        t_busy();
        t_broken();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule